// File: doc/BRIEF.md
# Bipolar Line-Code Decoder (AMI / HDB3 / B8ZS)

This block turns received bipolar line symbols into NRZ data. Each bit period brings one symbol as two flags, a positive-pulse flag and a negative-pulse flag. The symbol is taken when the recovered-clock enable `bitEn` is high at a rising edge of `clk`. A two-bit mode selects how the symbols are read:
- plain alternate-mark-inversion (AMI),
- the E1 four-zero substitution code (HDB3),
- the T1 eight-zero substitution code (B8ZS).

In the two substitution modes the decoder tracks the polarity of the last mark. A violation is a pulse with the same polarity as the mark just before it. The decoder uses violations to find the substitution codes, and clears the violation and balancing pulses so that the original zeros come back. In B8ZS mode a code is confirmed only eight symbols after it begins, so every mode runs through a short symbol pipeline with a fixed latency. That latency is 8 bit periods in B8ZS mode and 4 in AMI and HDB3 modes.

The output is either single-rail NRZ data or the raw positive and negative flags passed through with the same delay (dual-rail). A violation that fits no substitution code raises a one-clock error flag, and so does a symbol with both flags set. In both cases the bit is decoded as a one. The mode and rail format are set while reset is asserted and kept static until the next reset.

Top module: `bipolar_line_decoder`

## Requirements
- R1: While `rst_n` is low and after it rises with no `bitEn`, `rxData`, `rxNeg` and `violErr` are all 0.
- R2: With `codeMode` 00 (AMI; 11 behaves the same), a symbol with exactly one flag set decodes to 1 and a symbol with neither flag decodes to 0. Symbol k appears on `rxData` right after the 4th `bitEn` edge that follows its own.
- R3: With `codeMode` 01 (HDB3), both substitutions are restored to four zeros with a latency of 4. In 000V, V has the polarity of the preceding mark. In B00V, B is a mark and V has the same polarity as B. All other marks decode to 1.
- R4: With `codeMode` 10 (B8ZS), the substitution 0,0,0,P,−P,0,−P,P is restored to eight zeros with a latency of 8. Here P is the polarity of the mark before the group. All other marks decode to 1.
- R5: A violation that is not part of a recognised substitution, including any violation in AMI mode, decodes to 1. It sets `violErr` for the one clock in which that bit is on the output.
- R6: A symbol with both flags set decodes to 1 and sets `violErr` with that bit.
- R7: With `dualRail` = 1, `rxData` carries the raw positive flag and `rxNeg` the raw negative flag. Both are delayed by the latency of the mode, and substitution pulses are kept.
- R8: With `dualRail` = 0, `rxNeg` stays 0.
- R9: `rxData` and `rxNeg` change only at edges where `bitEn` is high. `violErr` is high for at most one clock after such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Recovered bit-clock enable; one symbol per high cycle |
| posIn | input | 1 | Positive-pulse flag of the current symbol |
| negIn | input | 1 | Negative-pulse flag of the current symbol |
| codeMode | input | 2 | 00 AMI, 01 HDB3, 10 B8ZS, 11 AMI |
| dualRail | input | 1 | 0 single-rail NRZ, 1 dual-rail pass-through |
| rxData | output | 1 | Decoded data (single-rail) or delayed positive flag (dual-rail) |
| rxNeg | output | 1 | Delayed negative flag (dual-rail), 0 in single-rail |
| violErr | output | 1 | One-clock flag for an unmatched violation or an illegal symbol |

## Verification
Long pseudo-random data streams are used, with about a third of the bits set so that zero runs of four, eight and more are frequent. The bench encodes each stream with its own HDB3 and B8ZS encoders, feeds it through the decoder and compares it bit for bit at the mode's latency. HDB3 streams contain both 000V and B00V forms, because the form depends on whether the count of marks is odd or even. This tells apart a decoder that clears the B pulse from one that clears only the V. B8ZS streams include back-to-back groups, and the same streams in dual-rail must come back with every substitution pulse intact. Short directed sequences then check the error cases: repeated polarity in AMI, a lone violation in B8ZS, and a symbol with both flags set. They also check that outputs hold between enables.

// File: rtl/bipolar_dec_pkg.sv
package bipolar_dec_pkg;
  // Symbol window: long enough for the eight-symbol B8ZS group
  localparam int WIN = 8;
  // Latency used by AMI and HDB3 (one four-symbol group)
  localparam int LAT_SHORT = 4;
  localparam int TAP_SHORT = LAT_SHORT - 1;
  localparam int TAP_LONG  = WIN - 1;

  typedef enum logic [1:0] {
    MODE_AMI  = 2'd0,
    MODE_HDB3 = 2'd1,
    MODE_B8ZS = 2'd2,
    MODE_AMI2 = 2'd3
  } codeMode_e;

  typedef struct packed {
    logic pos;
    logic neg;
    logic viol;
  } sym_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic           shiftEn;
    logic           newViol;
    logic [WIN-1:0] clrMask;
  } decStrobe_t;
endpackage

// File: rtl/bipolar_dec_ctrl.sv
module bipolar_dec_ctrl
  import bipolar_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitEn,
  input  logic             posIn,
  input  logic             negIn,
  input  logic [1:0]       codeMode,
  input  logic [WIN-2:0]   histPos,
  input  logic [WIN-2:0]   histNeg,
  input  logic             hist3Viol,
  output decStrobe_t       strobe
);
  codeMode_e mode;
  logic lastPos, haveMark;
  logic [WIN-1:0] wPos, wNeg, wZero, wOne;
  logic newViol, hit000V, hitB00V, hitB8zs;
  logic [WIN-1:0] clrMask;

  assign mode  = codeMode_e'(codeMode);
  // window index 0 is the incoming symbol, index k is k symbols older
  assign wPos  = {histPos, posIn};
  assign wNeg  = {histNeg, negIn};
  assign wZero = ~(wPos | wNeg);
  assign wOne  = wPos ^ wNeg;

  assign newViol = (posIn & negIn) |
                   (wOne[0] & haveMark & (posIn == lastPos));

  assign hit000V = newViol & wOne[0] & wZero[1] & wZero[2] & wZero[3];
  assign hitB00V = newViol & wOne[0] & wZero[1] & wZero[2] & wOne[3] &
                   (wPos[3] == wPos[0]);
  assign hitB8zs = wZero[7] & wZero[6] & wZero[5] &
                   wOne[4] & hist3Viol &
                   wOne[3] & (wPos[3] != wPos[4]) &
                   wZero[2] &
                   wOne[1] & (wPos[1] == wPos[3]) &
                   wOne[0] & (wPos[0] == wPos[4]);

  always_comb begin
    clrMask = '0;
    unique case (mode)
      MODE_HDB3: begin
        if (hitB00V)      clrMask = WIN'(9);   // V and B
        else if (hit000V) clrMask = WIN'(1);   // V only
      end
      MODE_B8ZS: begin
        if (hitB8zs)      clrMask = WIN'(8'b0001_1011);
      end
      default: clrMask = '0;
    endcase
  end

  assign strobe.shiftEn = bitEn;
  assign strobe.newViol = newViol;
  assign strobe.clrMask = bitEn ? clrMask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastPos  <= 1'b0;
      haveMark <= 1'b0;
    end else if (bitEn && wOne[0]) begin
      lastPos  <= posIn;
      haveMark <= 1'b1;
    end
  end

  // R2
  ami_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AMI || mode == MODE_AMI2) |-> strobe.clrMask == '0);
  // R3
  clear_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clrMask != '0) |-> (posIn ^ negIn));
  // R4
  b8zs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_B8ZS && strobe.clrMask != '0) |-> $countones(strobe.clrMask) == 4);
endmodule

// File: rtl/bipolar_dec_datapath.sv
module bipolar_dec_datapath
  import bipolar_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             posIn,
  input  logic             negIn,
  input  logic [1:0]       codeMode,
  input  logic             dualRail,
  input  decStrobe_t       strobe,
  output logic [WIN-2:0]   histPos,
  output logic [WIN-2:0]   histNeg,
  output logic             hist3Viol,
  output logic             rxData,
  output logic             rxNeg,
  output logic             violErr
);
  sym_t slotQ [WIN];
  logic [WIN-1:0] killQ;
  sym_t tapSym;
  logic tapKill, tapBit;

  for (genvar g = 0; g < WIN - 1; g++) begin : g_hist
    assign histPos[g] = slotQ[g].pos;
    assign histNeg[g] = slotQ[g].neg;
  end
  assign hist3Viol = slotQ[3].viol;

  always_comb begin
    if (codeMode_e'(codeMode) == MODE_B8ZS) begin
      tapSym  = slotQ[TAP_LONG];
      tapKill = killQ[TAP_LONG];
    end else begin
      tapSym  = slotQ[TAP_SHORT];
      tapKill = killQ[TAP_SHORT];
    end
    tapBit = (tapSym.pos | tapSym.neg) & ~tapKill;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WIN; k++) slotQ[k] <= '0;
      killQ   <= '0;
      rxData  <= 1'b0;
      rxNeg   <= 1'b0;
      violErr <= 1'b0;
    end else begin
      violErr <= 1'b0;
      if (strobe.shiftEn) begin
        slotQ[0] <= '{pos: posIn, neg: negIn, viol: strobe.newViol};
        for (int k = 1; k < WIN; k++) slotQ[k] <= slotQ[k-1];
        killQ   <= {killQ[WIN-2:0], 1'b0} | strobe.clrMask;
        rxData  <= dualRail ? tapSym.pos : tapBit;
        rxNeg   <= dualRail ? tapSym.neg : 1'b0;
        violErr <= tapSym.viol & ~tapKill;
      end
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.shiftEn) |-> ($stable(rxData) && $stable(rxNeg)));
  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violErr |-> $past(strobe.shiftEn));
  // R8
  single_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe.shiftEn) && !$past(dualRail)) |-> !rxNeg);
  // R5
  err_is_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (violErr && !$past(dualRail)) |-> rxData);
endmodule

// File: rtl/bipolar_line_decoder.sv
module bipolar_line_decoder
  import bipolar_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bitEn,
  input  logic       posIn,
  input  logic       negIn,
  input  logic [1:0] codeMode,
  input  logic       dualRail,
  output logic       rxData,
  output logic       rxNeg,
  output logic       violErr
);
  decStrobe_t     strobe;
  logic [WIN-2:0] histPos, histNeg;
  logic           hist3Viol;

  bipolar_dec_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .posIn(posIn), .negIn(negIn),
    .codeMode(codeMode), .histPos(histPos), .histNeg(histNeg),
    .hist3Viol(hist3Viol), .strobe(strobe)
  );

  bipolar_dec_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .posIn(posIn), .negIn(negIn),
    .codeMode(codeMode), .dualRail(dualRail), .strobe(strobe),
    .histPos(histPos), .histNeg(histNeg), .hist3Viol(hist3Viol),
    .rxData(rxData), .rxNeg(rxNeg), .violErr(violErr)
  );
endmodule

// File: tb/bipolar_line_decoder_tb_top.sv
module bipolar_line_decoder_tb_top;
  localparam int NMAX = 1200;
  localparam int NBITS = 700;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bitEn, posIn, negIn, dualRail;
  logic [1:0] codeMode;
  logic rxData, rxNeg, violErr;

  bipolar_line_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .posIn(posIn), .negIn(negIn),
    .codeMode(codeMode), .dualRail(dualRail),
    .rxData(rxData), .rxNeg(rxNeg), .violErr(violErr)
  );

  int nRun = 0, nFail = 0, symCnt = 0;
  bit datA [NMAX];
  bit encP [NMAX];
  bit encN [NMAX];
  bit capD [NMAX];
  bit capN [NMAX];
  bit capE [NMAX];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m, input logic dr);
    @(negedge clk);
    rst_n = 1'b0; bitEn = 1'b0; posIn = 1'b0; negIn = 1'b0;
    codeMode = m; dualRail = dr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    symCnt = 0;
  endtask

  task automatic sendSym(input bit p, input bit n);
    @(negedge clk);
    posIn = p; negIn = n; bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0; posIn = 1'b0; negIn = 1'b0;
    capD[symCnt] = rxData; capN[symCnt] = rxNeg; capE[symCnt] = violErr;
    @(negedge clk);
    // R9: hold between enables, error flag lasts one clock
    if (rxData !== capD[symCnt] || rxNeg !== capN[symCnt] || violErr !== 1'b0) begin
      nRun++; nFail++;
      $display("FAIL R9 hold: actual %0d%0d%0d expected %0d%0d0",
               rxData, rxNeg, violErr, capD[symCnt], capN[symCnt]);
    end
    symCnt++;
  endtask

  task automatic putPulse(input int j, input bit pol);
    encP[j] = pol; encN[j] = !pol;
  endtask

  // mode: 0 AMI, 1 HDB3, 2 B8ZS
  task automatic encode(input int mode, input int n);
    bit lastPos = 1'b0;
    int cnt = 0;
    int i = 0;
    for (int j = 0; j < NMAX; j++) begin encP[j] = 0; encN[j] = 0; end
    while (i < n) begin
      bool_block: begin
        if (mode == 1 && i + 3 < n && !datA[i] && !datA[i+1] && !datA[i+2] && !datA[i+3]) begin
          if (cnt % 2 == 1) begin
            putPulse(i + 3, lastPos);
          end else begin
            lastPos = !lastPos;
            putPulse(i, lastPos);
            putPulse(i + 3, lastPos);
          end
          cnt = 0; i += 4;
        end else if (mode == 2 && i + 7 < n && !datA[i] && !datA[i+1] && !datA[i+2] &&
                     !datA[i+3] && !datA[i+4] && !datA[i+5] && !datA[i+6] && !datA[i+7]) begin
          putPulse(i + 3, lastPos);  putPulse(i + 4, !lastPos);
          putPulse(i + 6, !lastPos); putPulse(i + 7, lastPos);
          i += 8;
        end else begin
          if (datA[i]) begin
            lastPos = !lastPos; putPulse(i, lastPos); cnt++;
          end
          i++;
        end
      end
    end
  endtask

  task automatic runStream(input int mode, input bit dr, input string req);
    int lat = (mode == 2) ? 8 : 4;
    int bad = 0;
    datA[0] = 1'b1;
    for (int j = 1; j < NBITS; j++) datA[j] = ($urandom % 10) < 3;
    for (int j = NBITS; j < NMAX; j++) datA[j] = 1'b0;
    encode(mode, NBITS);
    doReset(2'(mode), dr);
    for (int j = 0; j < NBITS + lat; j++) sendSym(encP[j], encN[j]);
    for (int k = lat; k < NBITS + lat; k++) begin
      if (!dr) begin
        if (capD[k] != datA[k-lat] || capN[k] || capE[k]) begin
          bad++;
          if (bad < 4)
            $display("FAIL %s bit %0d: actual %0d expected %0d (neg %0d err %0d)",
                     req, k - lat, capD[k], datA[k-lat], capN[k], capE[k]);
        end
      end else begin
        if (capD[k] != encP[k-lat] || capN[k] != encN[k-lat]) begin
          bad++;
          if (bad < 4)
            $display("FAIL %s sym %0d: actual %0d%0d expected %0d%0d",
                     req, k - lat, capD[k], capN[k], encP[k-lat], encN[k-lat]);
        end
      end
    end
    nRun++;
    if (bad != 0) nFail++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bitEn = 1'b0; posIn = 1'b0; negIn = 1'b0;
    codeMode = 2'd0; dualRail = 1'b0;
    doReset(2'd1, 1'b0);
    repeat (2) @(negedge clk);
    // R1 reset state
    check(rxData == 0 && rxNeg == 0 && violErr == 0, "R1 reset", {rxData, rxNeg, violErr}, 0);

    runStream(0, 1'b0, "R2 AMI stream");
    runStream(1, 1'b0, "R3 HDB3 stream");
    runStream(1, 1'b0, "R3 HDB3 stream 2");
    runStream(2, 1'b0, "R4 B8ZS stream");
    runStream(2, 1'b0, "R4 B8ZS stream 2");
    runStream(1, 1'b1, "R7 dual-rail HDB3");
    runStream(2, 1'b1, "R7 dual-rail B8ZS");

    // R5 AMI violation: +,+ then zeros
    doReset(2'd0, 1'b0);
    sendSym(1, 0); sendSym(1, 0);
    for (int j = 0; j < 5; j++) sendSym(0, 0);
    check(capD[4] == 1 && capE[4] == 0, "R2 AMI first mark", {capD[4], capE[4]}, 2);
    check(capD[5] == 1 && capE[5] == 1, "R5 AMI violation", {capD[5], capE[5]}, 3);
    check(capD[6] == 0 && capE[6] == 0, "R5 after violation", {capD[6], capE[6]}, 0);
    check(capN[5] == 0, "R8 single-rail neg", capN[5], 0);

    // R6 both flags in HDB3
    doReset(2'd1, 1'b0);
    sendSym(1, 0); sendSym(1, 1);
    for (int j = 0; j < 5; j++) sendSym(0, 0);
    check(capD[5] == 1 && capE[5] == 1, "R6 illegal symbol", {capD[5], capE[5]}, 3);
    check(capD[6] == 0 && capE[6] == 0, "R6 after illegal", {capD[6], capE[6]}, 0);

    // R5 lone violation in B8ZS: + 0 0 0 + then zeros
    doReset(2'd2, 1'b0);
    sendSym(1, 0);
    for (int j = 0; j < 3; j++) sendSym(0, 0);
    sendSym(1, 0);
    for (int j = 0; j < 9; j++) sendSym(0, 0);
    check(capD[8] == 1 && capE[8] == 0, "R4 B8ZS latency mark", {capD[8], capE[8]}, 2);
    check(capD[11] == 0, "R4 B8ZS zero", capD[11], 0);
    check(capD[12] == 1 && capE[12] == 1, "R5 B8ZS lone violation", {capD[12], capE[12]}, 3);

    // R3 directed B00V: + then 0000 encoded as - 0 0 -
    doReset(2'd1, 1'b0);
    sendSym(1, 0); sendSym(0, 1); sendSym(0, 0); sendSym(0, 0); sendSym(0, 1);
    sendSym(1, 0);
    for (int j = 0; j < 5; j++) sendSym(0, 0);
    check(capD[4] == 1, "R3 B00V lead mark", capD[4], 1);
    check({capD[5], capD[6], capD[7], capD[8]} == 4'b0000 && !capE[8],
          "R3 B00V cleared", {capD[5], capD[6], capD[7], capD[8]}, 0);
    check(capD[9] == 1 && capE[9] == 0, "R3 mark after B00V", {capD[9], capE[9]}, 2);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule